// File: doc/BRIEF.md
# EEPROM Status Register and Write Permission Unit

This unit sits between the command decoder of a serial EEPROM and its storage array. It holds the device status byte and rules on every write request. The status byte carries the write-enable latch, a busy flag, two block-protect bits that select a protected top region of the array, and a protect-enable bit that arms the external write-protect pin. The decoder sends single-cycle pulses: enable or disable writes, a status-write request carrying the data byte, and a memory-write request carrying the target address. One cycle later the unit answers each request with a grant or a deny pulse.

The unit tracks the chip select line. Granted writes stay pending until chip select rises. At that edge an internal write cycle of fixed length starts, and the busy flag stays set for its whole length. New status values take effect when the cycle ends. At the same moment the write-enable latch drops. The protect bits do not return to their power-up value on reset, because they model non-volatile storage.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: `status_byte` reads {protect-enable, 0, 0, 0, BP1, BP0, write-enable latch, busy}, from bit 7 down to bit 0. Bits 6:4 are always 0, and bit 0 is 1 exactly while an internal write cycle runs.
- R2: A `wren_cmd` pulse sets the latch (bit 1) at the next edge and a `wrdi_cmd` pulse clears it; when both come together the clear wins.
- R3: Each `mem_wr_req` gets exactly one response pulse, one cycle later. It is a grant only if the unit is idle, the latch is 1 and the address lies outside the protected region; otherwise it is a deny.
- R4: With array size D = 2^ADDR_W, the protected region is chosen by BP1:BP0. The value 00 protects no address. The value 01 protects addresses at or above 3D/4, 10 protects those at or above D/2, and 11 protects every address.
- R5: Each `sr_wr_req` gets exactly one response, one cycle later. It is a grant only if the unit is idle, the latch is 1 and the lock is off; the lock is on when protect-enable is 1 and `wp_n` is 0. A granted status write alters only bits 7, 3 and 2, and only when its internal cycle ends.
- R6: While protect-enable is 0, the level of `wp_n` has no effect on any decision.
- R7: A granted status write is cancelled if, while `cs_n` is still low, an edge samples `wp_n` low with protect-enable at 1. A cancelled write starts no cycle and changes no bit.
- R8: A rising `cs_n` with a granted write pending starts an internal cycle: bit 0 is 1 for exactly WRITE_CYCLES cycles from the next edge. `wp_n` changes during the cycle do not alter the commit.
- R9: When an internal cycle ends, the write-enable latch is cleared.
- R10: Synchronous `rst` clears the latch, the busy flag and any pending write. Bits 7, 3 and 2 keep their values across it; they start from INIT_NV at power-up.
- R11: While busy, enable and disable pulses have no effect and every write request is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low during a transfer |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| wren_cmd | input | 1 | Pulse: set write-enable latch |
| wrdi_cmd | input | 1 | Pulse: clear write-enable latch |
| sr_wr_req | input | 1 | Pulse: status write request |
| sr_wr_data | input | 8 | Status byte to write |
| mem_wr_req | input | 1 | Pulse: memory write request |
| mem_wr_addr | input | ADDR_W | Target address of memory write |
| status_byte | output | 8 | Formatted status byte |
| mem_wr_grant | output | 1 | Memory write allowed |
| mem_wr_deny | output | 1 | Memory write refused |
| sr_wr_grant | output | 1 | Status write allowed |
| sr_wr_deny | output | 1 | Status write refused |

## Verification
The bench builds the unit with ADDR_W = 11, a 2048-byte array. This makes the quarter and half boundaries at 0x600 and 0x400 differ from those of the default 1024-byte build, so a region start wired for one size fails there. WRITE_CYCLES = 6 keeps the busy window short enough that many full write cycles fit in a run. It is still long enough that commands can be issued inside it. A behavioural model follows cancellation, pin changes during a cycle and resets during a pending write, which the random transfers reach many times.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int BIT_WPEN = 7;
  localparam int BIT_BP1  = 3;
  localparam int BIT_BP0  = 2;
  localparam int BIT_WEL  = 1;
  localparam int BIT_BUSY = 0;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_e;

  function automatic logic [7:0] pack_status(logic wpen, prot_e bp, logic wel, logic busy);
    return {wpen, 3'b000, bp, wel, busy};
  endfunction
endpackage

// File: rtl/wpc_prot_map.sv
module wpc_prot_map
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  prot_e             mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam longint DEPTH = 64'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(DEPTH - DEPTH / 4);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(DEPTH / 2);

  always_comb begin
    case (mode)
      PROT_NONE: hit = 1'b0;
      PROT_QTR:  hit = (addr >= QTR_BASE);
      PROT_HALF: hit = (addr >= HALF_BASE);
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign done = busy && (cnt == LAST);
endmodule

// File: rtl/wpc_status_core.sv
module wpc_status_core
  import wpc_pkg::*;
#(
  parameter logic [7:0] INIT_NV = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       wp_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       sr_take,
  input  logic [7:0] sr_din,
  input  logic       mem_take,
  input  logic       busy,
  input  logic       done,
  output logic       wel,
  output logic       wpen,
  output prot_e      bp,
  output logic       start
);
  logic  cs_q;
  logic  sr_pend;
  logic  mem_pend;
  logic  commit;
  logic  hold_wpen;
  prot_e hold_bp;
  logic  wpen_q = INIT_NV[BIT_WPEN];
  prot_e bp_q   = prot_e'(INIT_NV[BIT_BP1:BIT_BP0]);

  assign start = !cs_q && cs_n && !busy && (sr_pend || mem_pend);
  assign wpen  = wpen_q;
  assign bp    = bp_q;

  // latch and transfer tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      wel      <= 1'b0;
      cs_q     <= 1'b1;
      sr_pend  <= 1'b0;
      mem_pend <= 1'b0;
      commit   <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (done) begin
        wel    <= 1'b0;
        commit <= 1'b0;
      end else if (!busy) begin
        if (clr_wel)      wel <= 1'b0;
        else if (set_wel) wel <= 1'b1;
      end
      if (start) begin
        commit   <= sr_pend;
        sr_pend  <= 1'b0;
        mem_pend <= 1'b0;
      end else begin
        if (sr_pend && !cs_n && wpen_q && !wp_n) sr_pend <= 1'b0;
        if (sr_take)  sr_pend  <= 1'b1;
        if (mem_take) mem_pend <= 1'b1;
      end
    end
  end

  // captured status data, no reset needed
  always_ff @(posedge clk) begin
    if (sr_take) begin
      hold_wpen <= sr_din[BIT_WPEN];
      hold_bp   <= prot_e'(sr_din[BIT_BP1:BIT_BP0]);
    end
  end

  // non-volatile bits: untouched by reset
  always_ff @(posedge clk) begin
    if (!rst && done && commit) begin
      wpen_q <= hold_wpen;
      bp_q   <= hold_bp;
    end
  end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import wpc_pkg::*;
#(
  parameter int         ADDR_W       = 10,
  parameter int         WRITE_CYCLES = 8,
  parameter logic [7:0] INIT_NV      = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              wren_cmd,
  input  logic              wrdi_cmd,
  input  logic              sr_wr_req,
  input  logic [7:0]        sr_wr_data,
  input  logic              mem_wr_req,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        status_byte,
  output logic              mem_wr_grant,
  output logic              mem_wr_deny,
  output logic              sr_wr_grant,
  output logic              sr_wr_deny
);
  logic  busy, done, start, wel, wpen, hit;
  prot_e bp;
  logic  mem_ok, sr_ok;

  wpc_prot_map #(.ADDR_W(ADDR_W)) u_map (
    .mode(bp), .addr(mem_wr_addr), .hit(hit)
  );

  wpc_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  assign mem_ok = !busy && wel && !hit;
  assign sr_ok  = !busy && wel && !(wpen && !wp_n);

  wpc_status_core #(.INIT_NV(INIT_NV)) u_core (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n),
    .set_wel(wren_cmd), .clr_wel(wrdi_cmd),
    .sr_take(sr_wr_req && sr_ok), .sr_din(sr_wr_data),
    .mem_take(mem_wr_req && mem_ok),
    .busy(busy), .done(done),
    .wel(wel), .wpen(wpen), .bp(bp), .start(start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_grant <= 1'b0;
      mem_wr_deny  <= 1'b0;
      sr_wr_grant  <= 1'b0;
      sr_wr_deny   <= 1'b0;
    end else begin
      mem_wr_grant <= mem_wr_req && mem_ok;
      mem_wr_deny  <= mem_wr_req && !mem_ok;
      sr_wr_grant  <= sr_wr_req && sr_ok;
      sr_wr_deny   <= sr_wr_req && !sr_ok;
    end
  end

  assign status_byte = pack_status(wpen, bp, wel, busy);
endmodule

// File: rtl/eeprom_wp_ctrl_chk.sv
module eeprom_wp_ctrl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wp_n,
  input logic              wren_cmd,
  input logic              wrdi_cmd,
  input logic              sr_wr_req,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [7:0]        status_byte,
  input logic              mem_wr_grant,
  input logic              mem_wr_deny,
  input logic              sr_wr_grant,
  input logic              sr_wr_deny
);
  p_mem_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_grant && mem_wr_deny));
  p_sr_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(sr_wr_grant && sr_wr_deny));
  p_full_lock_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req && (status_byte[3:2] == 2'b11) |=> !mem_wr_grant);
  p_wren_sets_r2: assert property (@(posedge clk) disable iff (rst)
    wren_cmd && !wrdi_cmd && !status_byte[0] |=> status_byte[1]);
  p_lock_denies_r5: assert property (@(posedge clk) disable iff (rst)
    sr_wr_req && status_byte[7] && !wp_n |=> sr_wr_deny);
  p_pin_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    sr_wr_req && !status_byte[7] && status_byte[1] && !status_byte[0] |=> sr_wr_grant);
  p_busy_denies_r11: assert property (@(posedge clk) disable iff (rst)
    status_byte[0] && mem_wr_req |=> mem_wr_deny);
  p_wel_drop_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(status_byte[0]) |-> !status_byte[1]);
  p_nv_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$fell(status_byte[0]) |-> $stable({status_byte[7], status_byte[3:2]}));
endmodule

bind eeprom_wp_ctrl eeprom_wp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wp_n(wp_n), .wren_cmd(wren_cmd), .wrdi_cmd(wrdi_cmd),
  .sr_wr_req(sr_wr_req), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
  .status_byte(status_byte), .mem_wr_grant(mem_wr_grant), .mem_wr_deny(mem_wr_deny),
  .sr_wr_grant(sr_wr_grant), .sr_wr_deny(sr_wr_deny)
);

// File: tb/eeprom_wp_ctrl_tb.sv
module eeprom_wp_ctrl_tb;
  localparam int PERIOD = 10;
  localparam int AW = 11;
  localparam int WC = 6;
  localparam int D  = 1 << AW;

  logic clk = 0, rst = 1, cs_n = 1, wp_n = 1;
  logic wren = 0, wrdi = 0, sr_req = 0, mem_req = 0;
  logic [7:0] sr_data = 0;
  logic [AW-1:0] addr = 0;
  logic [7:0] status;
  logic mg, md, sg, sd;

  int checks = 0, fails = 0;
  bit started = 0, finished = 0;

  always #(PERIOD/2) clk = ~clk;

  eeprom_wp_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC), .INIT_NV(8'h00)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n), .wren_cmd(wren), .wrdi_cmd(wrdi),
    .sr_wr_req(sr_req), .sr_wr_data(sr_data), .mem_wr_req(mem_req), .mem_wr_addr(addr),
    .status_byte(status), .mem_wr_grant(mg), .mem_wr_deny(md),
    .sr_wr_grant(sg), .sr_wr_deny(sd)
  );

  // behavioural reference model
  int m_left = 0;
  bit m_wel = 0, m_wpen = 0, m_commit = 0, m_srp = 0, m_memp = 0, m_csq = 1;
  bit [1:0] m_bp = 0;
  bit [7:0] m_srd = 0, m_cd = 0;
  bit m_mg = 0, m_md = 0, m_sg = 0, m_sd = 0;
  bit b0, lk, pr;

  function automatic bit prot(bit [1:0] bpv, int a);
    if (bpv == 2'b11) return 1;
    if (bpv == 2'b10) return a >= D / 2;
    if (bpv == 2'b01) return a >= (3 * D) / 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_left = 0; m_wel = 0; m_commit = 0; m_srp = 0; m_memp = 0; m_csq = 1;
      m_mg = 0; m_md = 0; m_sg = 0; m_sd = 0;
    end else begin
      b0 = (m_left > 0);
      lk = m_wpen && !wp_n;
      pr = prot(m_bp, int'(addr));
      m_mg = mem_req && !b0 && m_wel && !pr;
      m_md = mem_req && !m_mg;
      m_sg = sr_req && !b0 && m_wel && !lk;
      m_sd = sr_req && !m_sg;
      if (b0 && m_left == 1) begin
        m_wel = 0;
        if (m_commit) begin m_wpen = m_cd[7]; m_bp = m_cd[3:2]; end
        m_commit = 0;
      end else if (!b0) begin
        if (wrdi) m_wel = 0;
        else if (wren) m_wel = 1;
      end
      if (b0) m_left = m_left - 1;
      if (!m_csq && cs_n && !b0 && (m_srp || m_memp)) begin
        m_left = WC; m_commit = m_srp; m_cd = m_srd; m_srp = 0; m_memp = 0;
      end else begin
        if (m_srp && !cs_n && lk) m_srp = 0;
        if (m_sg) begin m_srp = 1; m_srd = sr_data; end
        if (m_mg) m_memp = 1;
      end
      m_csq = cs_n;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !finished) begin
      check("R1 status", status, {m_wpen, 3'b000, m_bp, m_wel, m_left > 0});
      check("R3 mem response", {6'd0, mg, md}, {6'd0, m_mg, m_md});
      check("R5 status-write response", {6'd0, sg, sd}, {6'd0, m_sg, m_sd});
    end
  end

  task automatic step; @(negedge clk); endtask
  task automatic do_wren; wren = 1; step(); wren = 0; endtask
  task automatic do_wrdi; wrdi = 1; step(); wrdi = 0; endtask
  task automatic do_mem(input int a); mem_req = 1; addr = AW'(a); step(); mem_req = 0; endtask
  task automatic do_sr(input logic [7:0] v); sr_req = 1; sr_data = v; step(); sr_req = 0; endtask
  task automatic cs_lo; cs_n = 0; step(); endtask
  task automatic cs_hi; cs_n = 1; step(); endtask
  task automatic wait_idle; repeat (WC + 1) step(); endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    check("R1 R10 reset state", status, 8'h00);
    cs_lo(); do_mem(16); check("R3 deny without latch", {mg, md}, 2'b01); cs_hi();
    do_wren(); check("R2 wren sets latch", status, 8'h02);
    do_wrdi(); check("R2 wrdi clears latch", status, 8'h00);
    do_wren();
    cs_lo(); do_mem(12'h7FF); check("R3 grant unprotected", {mg, md}, 2'b10);
    cs_hi(); check("R8 busy after cs rise", status, 8'h03);
    do_wrdi(); check("R11 wrdi ignored busy", status, 8'h03);
    do_mem(0); check("R11 deny while busy", {mg, md}, 2'b01);
    wait_idle(); check("R9 latch cleared at end", status, 8'h00);
    do_wren(); cs_lo(); do_sr(8'hFF); check("R5 status grant", {sg, sd}, 2'b10);
    cs_hi(); check("R5 not yet committed", status, 8'h03);
    wait_idle(); check("R5 R1 only 7,3,2 written", status, 8'h8C);
    do_wren(); cs_lo(); do_mem(0); check("R4 full protect", {mg, md}, 2'b01);
    cs_hi(); check("R8 no cycle without pending", status, 8'h8E);
    cs_lo(); do_sr(8'h84); cs_hi(); wait_idle(); check("R5 bp quarter", status, 8'h84);
    do_wren(); cs_lo();
    do_mem(12'h5FF); check("R4 below quarter base", {mg, md}, 2'b10);
    do_mem(12'h600); check("R4 quarter base", {mg, md}, 2'b01);
    cs_hi(); wait_idle();
    wp_n = 0; do_wren(); cs_lo();
    do_sr(8'h00); check("R5 locked by pin", {sg, sd}, 2'b01);
    do_mem(12'h100); check("R3 pin keeps free area writable", {mg, md}, 2'b10);
    cs_hi(); wait_idle(); check("R5 lock kept bits", status, 8'h84);
    wp_n = 1; do_wren(); cs_lo(); do_sr(8'h88);
    wp_n = 0; step(); wp_n = 1; cs_hi();
    check("R7 cancelled write starts no cycle", status, 8'h86);
    cs_lo(); do_sr(8'h08); cs_hi(); wp_n = 0; wait_idle();
    check("R8 pin during cycle ignored", status, 8'h08);
    do_wren(); cs_lo(); do_mem(12'h3FF); check("R4 below half base", {mg, md}, 2'b10);
    do_mem(12'h400); check("R4 half base", {mg, md}, 2'b01); cs_hi(); wait_idle();
    do_wren(); cs_lo(); do_sr(8'h04); check("R6 pin ignored", {sg, sd}, 2'b10);
    cs_hi(); wait_idle(); check("R6 commit with pin low", status, 8'h04);
    do_wren(); rst = 1; step(); rst = 0; check("R10 reset keeps nv", status, 8'h04);
    for (int t = 0; t < 400; t++) begin
      cs_lo();
      for (int k = 0; k < 1 + $urandom_range(0, 3); k++) begin
        case ($urandom_range(0, 5))
          0: do_wren();
          1: do_wrdi();
          2: do_mem($urandom_range(0, D - 1));
          3: do_sr(8'($urandom));
          4: begin wp_n = ~wp_n; step(); end
          default: step();
        endcase
      end
      cs_hi();
      if ($urandom_range(0, 30) == 0) begin rst = 1; step(); rst = 0; end
      repeat ($urandom_range(0, 8)) step();
    end
    finished = 1;
    summary();
  end
endmodule